// File: doc/BRIEF.md
# Misaligned Load/Store Splitter

This block sits between a core's load/store unit and a word-wide memory bus. The core hands it one request at a time: a byte, halfword or word at any byte address, with data held right-justified. The block turns that request into one or two naturally aligned bus transfers. Each transfer carries a per-lane byte strobe. The core never sees how the access was cut up.

An access that fits inside one bus word costs a single transfer. An access that runs past a word boundary is issued as two back-to-back transfers, to the lower word and then the next one. For a read, the bytes of both words are stitched into one zero-extended, right-justified result. For a write, the data is rotated so that every byte lands on its lane, and the strobes pick out which lanes each transfer may touch.

Some access classes may never be split: exclusive, stack and load/store-multiple. If one of these arrives misaligned, the block answers at once with an alignment fault and leaves the bus untouched. Lane order is little-endian throughout.

Top module: `unaligned_splitter`

## Requirements
- R1: After synchronous reset, req_ready is 1 and both bus_valid and rsp_done are 0.
- R2: The offset is the address modulo 4. Size codes are 0 for byte (1 byte), 1 for halfword (2 bytes) and 2 for word (4 bytes). When offset plus byte count is at most 4, the access uses exactly one bus transfer. That transfer goes to the address with bits [1:0] cleared, and strobe bit j is set exactly for lanes offset <= j < offset+bytes.
- R3: When offset plus byte count exceeds 4, the access uses exactly two transfers. The first goes to the cleared address with strobes for lanes offset..3. The second goes to that address plus 4 with strobes for lanes 0..offset+bytes-5.
- R4: On a write, byte i of req_wdata (bits 8i+7:8i) is stored at byte address req_addr+i. No other memory byte changes.
- R5: On a read, rsp_rdata byte i equals the memory byte at req_addr+i for i below the byte count, and the upper bytes are zero. On a write, rsp_rdata is zero.
- R6: Kind codes are 0 plain, 1 exclusive, 2 stack and 3 multiple. A request of kind 1, 2 or 3 is misaligned when it is a halfword at an odd address or a word whose offset is not 0. Such a request completes with rsp_fault=1 in the cycle after acceptance, and no bus transfer is made. A plain request, or an aligned request of any kind, never faults.
- R7: Size code 3 is rejected with rsp_fault=1 in the cycle after acceptance, with no bus transfer, whatever the kind.
- R8: rsp_done is a one-cycle pulse. It rises in the cycle after the final bus acknowledge. req_ready stays low from acceptance until the cycle after rsp_done.
- R9: While bus_valid is high and bus_ack is low, bus_valid, bus_addr, bus_strb and bus_wdata stay unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | ADDR_W | Byte address of the access |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 illegal |
| req_write | input | 1 | 1 for store, 0 for load |
| req_kind | input | 2 | 0 plain, 1 exclusive, 2 stack, 3 multiple |
| req_wdata | input | DATA_W | Right-justified store data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_fault | output | 1 | Alignment or size fault, valid with rsp_done |
| rsp_rdata | output | DATA_W | Right-justified, zero-extended load result |
| bus_valid | output | 1 | Bus transfer requested |
| bus_addr | output | ADDR_W | Word-aligned transfer address |
| bus_write | output | 1 | Transfer direction |
| bus_strb | output | DATA_W/8 | Byte-lane enables |
| bus_wdata | output | DATA_W | Lane-steered write data |
| bus_ack | input | 1 | Transfer complete, read data valid |
| bus_rdata | input | DATA_W | Read data of the acknowledged transfer |

## Verification
Directed cases first step through every offset for halfword and word, for both loads and stores. These show apart the one-transfer and the two-transfer paths, as well as the halfword at offset 1 that stays within its word. Each protected kind is then sent once misaligned and once aligned, and size code 3 is sent as well, which separates a genuine fault from a false rejection. After that, a seeded random mix of addresses, sizes, kinds and bus wait states runs against a byte-level shadow memory. Any lane or strobe mistake shows up as a wrong result or as a corrupted neighbouring byte.

// File: rtl/uas_pkg.sv
package uas_pkg;

  typedef enum logic [1:0] {
    KIND_PLAIN = 2'd0,
    KIND_EXCL  = 2'd1,
    KIND_STACK = 2'd2,
    KIND_MULTI = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2,
    ST_RESP   = 2'd3
  } split_state_e;

endpackage

// File: rtl/uas_plan.sv
module uas_plan
  import uas_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int OFF_W  = 2,
  parameter int SIZE_W = 2
) (
  input  logic [OFF_W-1:0]  off,
  input  logic [SIZE_W-1:0] size,
  input  logic [1:0]        kind,
  output logic [LANES-1:0]  strb_lo,
  output logic [LANES-1:0]  strb_hi,
  output logic              two_xfer,
  output logic              fault
);

  logic [2*LANES-1:0] span;
  logic               size_ok;
  logic               misalign;
  acc_kind_e          kind_e;
  int                 nbytes;

  always_comb begin
    kind_e   = acc_kind_e'(kind);
    nbytes   = 1 << size;
    size_ok  = int'(size) <= OFF_W;
    misalign = (int'(off) % nbytes) != 0;
    for (int j = 0; j < 2*LANES; j++) begin
      span[j] = (j >= int'(off)) && (j < int'(off) + nbytes);
    end
    strb_lo  = span[LANES-1:0];
    strb_hi  = span[2*LANES-1:LANES];
    two_xfer = |strb_hi;
    fault    = !size_ok || ((kind_e != KIND_PLAIN) && misalign);
  end

endmodule

// File: rtl/uas_steer.sv
module uas_steer #(
  parameter int LANES = 4,
  parameter int OFF_W = 2
) (
  input  logic [8*LANES-1:0] data_in,
  input  logic [OFF_W-1:0]   off,
  output logic [8*LANES-1:0] data_rot
);

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [OFF_W-1:0] src;
    assign src = OFF_W'(j) - off;
    assign data_rot[8*j +: 8] = data_in[8*src +: 8];
  end

endmodule

// File: rtl/uas_merge.sv
module uas_merge #(
  parameter int LANES  = 4,
  parameter int OFF_W  = 2,
  parameter int SIZE_W = 2
) (
  input  logic [8*LANES-1:0] lo_word,
  input  logic [8*LANES-1:0] hi_word,
  input  logic [OFF_W-1:0]   off,
  input  logic [SIZE_W-1:0]  size,
  output logic [8*LANES-1:0] result
);

  logic [7:0] nbytes;
  assign nbytes = 8'(1) << size;

  for (genvar i = 0; i < LANES; i++) begin : g_byte
    logic [OFF_W:0]   pos;
    logic [OFF_W-1:0] lane;
    logic [7:0]       picked;
    assign pos    = {1'b0, off} + (OFF_W+1)'(i);
    assign lane   = pos[OFF_W-1:0];
    assign picked = pos[OFF_W] ? hi_word[8*lane +: 8] : lo_word[8*lane +: 8];
    assign result[8*i +: 8] = (8'(i) < nbytes) ? picked : 8'h00;
  end

endmodule

// File: rtl/unaligned_splitter.sv
module unaligned_splitter
  import uas_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [1:0]          req_size,
  input  logic                req_write,
  input  logic [1:0]          req_kind,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                rsp_done,
  output logic                rsp_fault,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                bus_valid,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic                bus_write,
  output logic [DATA_W/8-1:0] bus_strb,
  output logic [DATA_W-1:0]   bus_wdata,
  input  logic                bus_ack,
  input  logic [DATA_W-1:0]   bus_rdata
);

  localparam int LANES  = DATA_W / 8;
  localparam int OFF_W  = $clog2(LANES);
  localparam int SIZE_W = 2;

  split_state_e      state;
  logic [LANES-1:0]  strb_lo, strb_hi, hi_strb_q;
  logic              two_xfer, plan_fault, two_q;
  logic [OFF_W-1:0]  off_q;
  logic [SIZE_W-1:0] size_q;
  logic [DATA_W-1:0] rot_data, lo_word_q, merge_lo, merge_hi, merged;

  uas_plan #(.LANES(LANES), .OFF_W(OFF_W), .SIZE_W(SIZE_W)) u_plan (
    .off      (req_addr[OFF_W-1:0]),
    .size     (req_size),
    .kind     (req_kind),
    .strb_lo  (strb_lo),
    .strb_hi  (strb_hi),
    .two_xfer (two_xfer),
    .fault    (plan_fault)
  );

  uas_steer #(.LANES(LANES), .OFF_W(OFF_W)) u_steer (
    .data_in  (req_wdata),
    .off      (req_addr[OFF_W-1:0]),
    .data_rot (rot_data)
  );

  assign merge_lo = (state == ST_SECOND) ? lo_word_q : bus_rdata;
  assign merge_hi = (state == ST_SECOND) ? bus_rdata : '0;

  uas_merge #(.LANES(LANES), .OFF_W(OFF_W), .SIZE_W(SIZE_W)) u_merge (
    .lo_word (merge_lo),
    .hi_word (merge_hi),
    .off     (off_q),
    .size    (size_q),
    .result  (merged)
  );

  assign req_ready = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bus_valid <= 1'b0;
      bus_addr  <= '0;
      bus_write <= 1'b0;
      bus_strb  <= '0;
      bus_wdata <= '0;
      hi_strb_q <= '0;
      two_q     <= 1'b0;
      off_q     <= '0;
      size_q    <= '0;
      lo_word_q <= '0;
      rsp_done  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            off_q  <= req_addr[OFF_W-1:0];
            size_q <= req_size;
            if (plan_fault) begin
              rsp_done  <= 1'b1;
              rsp_fault <= 1'b1;
              rsp_rdata <= '0;
              state     <= ST_RESP;
            end else begin
              bus_valid <= 1'b1;
              bus_addr  <= {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
              bus_write <= req_write;
              bus_strb  <= strb_lo;
              bus_wdata <= rot_data;
              hi_strb_q <= strb_hi;
              two_q     <= two_xfer;
              state     <= ST_FIRST;
            end
          end
        end
        ST_FIRST: begin
          if (bus_ack) begin
            if (two_q) begin
              lo_word_q <= bus_rdata;
              bus_addr  <= bus_addr + ADDR_W'(LANES);
              bus_strb  <= hi_strb_q;
              state     <= ST_SECOND;
            end else begin
              bus_valid <= 1'b0;
              rsp_done  <= 1'b1;
              rsp_fault <= 1'b0;
              rsp_rdata <= bus_write ? '0 : merged;
              state     <= ST_RESP;
            end
          end
        end
        ST_SECOND: begin
          if (bus_ack) begin
            bus_valid <= 1'b0;
            rsp_done  <= 1'b1;
            rsp_fault <= 1'b0;
            rsp_rdata <= bus_write ? '0 : merged;
            state     <= ST_RESP;
          end
        end
        default: begin
          rsp_done  <= 1'b0;
          rsp_fault <= 1'b0;
          state     <= ST_IDLE;
        end
      endcase
    end
  end

  // R2: every transfer is word aligned and enables at least one lane
  assert_bus_aligned_R2: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> (bus_addr[OFF_W-1:0] == '0) && (bus_strb != '0));

  // R9: a pending transfer holds still until acknowledged
  assert_bus_hold_R9: assert property (@(posedge clk) disable iff (rst)
    bus_valid && !bus_ack |=> bus_valid && $stable(bus_addr) &&
    $stable(bus_strb) && $stable(bus_wdata));

  // R8: good completion only right after an acknowledged transfer
  assert_done_after_ack_R8: assert property (@(posedge clk) disable iff (rst)
    rsp_done && !rsp_fault |-> $past(bus_valid && bus_ack));

  // R8: completion is a single-cycle pulse
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  // R8: no new request accepted while bus activity is open
  assert_ready_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !(req_ready && bus_valid));

  // R6: a faulted completion never follows a bus transfer
  assert_fault_no_bus_R6: assert property (@(posedge clk) disable iff (rst)
    rsp_done && rsp_fault |-> !bus_valid && !$past(bus_valid));

endmodule

// File: tb/test_unaligned_splitter.sv
module test_unaligned_splitter;

  localparam int AW = 32;
  localparam int DW = 32;
  localparam int MEMB = 128;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_size = '0;
  logic          req_write = 1'b0;
  logic [1:0]    req_kind = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_done, rsp_fault;
  logic [DW-1:0] rsp_rdata;
  logic          bus_valid, bus_write;
  logic [AW-1:0] bus_addr;
  logic [3:0]    bus_strb;
  logic [DW-1:0] bus_wdata;
  logic          bus_ack = 1'b0;
  logic [DW-1:0] bus_rdata = '0;

  unaligned_splitter #(.ADDR_W(AW), .DATA_W(DW)) i_unaligned_splitter (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .req_kind(req_kind),
    .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_fault(rsp_fault), .rsp_rdata(rsp_rdata),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_write(bus_write),
    .bus_strb(bus_strb), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  always #10 clk = ~clk;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int ack_cyc = 0;
  int xfer_n = 0;
  logic [AW-1:0] xa [0:1];
  logic [3:0]    xs [0:1];
  logic [7:0] mem    [0:MEMB-1];
  logic [7:0] shadow [0:MEMB-1];
  int unsigned seed_sink;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Bus responder: acts shortly after each rising edge
  initial begin
    int wait_left;
    bit held;
    logic [AW-1:0] h_addr;
    logic [3:0] h_strb;
    logic [DW-1:0] h_wdata;
    wait_left = 0;
    held = 1'b0;
    h_addr = '0; h_strb = '0; h_wdata = '0;
    forever begin
      @(posedge clk);
      #2;
      cyc++;
      bus_ack = 1'b0;
      if (rst || !bus_valid) begin
        held = 1'b0;
      end else begin
        if (held) begin
          chk(bus_addr == h_addr && bus_strb == h_strb && bus_wdata == h_wdata,
              "R9 hold", bus_addr, h_addr);
        end
        if (wait_left == 0) begin
          int base;
          base = int'(bus_addr[6:0]);
          bus_ack = 1'b1;
          bus_rdata = {mem[base+3], mem[base+2], mem[base+1], mem[base]};
          if (bus_write) begin
            for (int j = 0; j < 4; j++)
              if (bus_strb[j]) mem[base+j] = bus_wdata[8*j +: 8];
          end
          if (xfer_n < 2) begin
            xa[xfer_n] = bus_addr;
            xs[xfer_n] = bus_strb;
          end
          xfer_n++;
          ack_cyc = cyc;
          wait_left = int'($urandom % 3);
          held = 1'b0;
        end else begin
          wait_left--;
          held = 1'b1;
          h_addr = bus_addr; h_strb = bus_strb; h_wdata = bus_wdata;
        end
      end
    end
  end

  function automatic logic [7:0] lane_span(int off, int n);
    logic [7:0] s;
    for (int j = 0; j < 8; j++) s[j] = (j >= off) && (j < off + n);
    return s;
  endfunction

  task automatic access(input int addr, input int size, input bit wr,
                        input logic [31:0] wdata, input int kind);
    int c0, done_cyc, n, off, nx, waited;
    bit fault_exp, mis;
    logic [31:0] got, exp_r;
    logic [7:0] sp;
    bit got_fault;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    xfer_n = 0;
    req_valid = 1'b1;
    req_addr = AW'(addr);
    req_size = 2'(size);
    req_write = wr;
    req_wdata = wdata;
    req_kind = 2'(kind);
    c0 = cyc;
    @(negedge clk);
    req_valid = 1'b0;
    waited = 0;
    while (!rsp_done && waited < 40) begin
      if (req_ready) begin
        chk(1'b0, "R8 ready low while busy", 32'(req_ready), 32'd0);
      end
      @(negedge clk);
      waited++;
    end
    done_cyc = cyc;
    got = rsp_rdata;
    got_fault = rsp_fault;
    n = 1 << size;
    off = addr % 4;
    mis = (size == 1 && (off % 2) != 0) || (size == 2 && off != 0);
    fault_exp = (size == 3) || (kind != 0 && mis);
    if (fault_exp) begin
      if (size == 3)
        chk(got_fault == 1'b1 && xfer_n == 0, "R7 size fault", 32'(xfer_n), 32'd0);
      else
        chk(got_fault == 1'b1 && xfer_n == 0, "R6 kind fault", 32'(xfer_n), 32'd0);
      chk(done_cyc == c0 + 1, "R6 fault timing", 32'(done_cyc), 32'(c0 + 1));
    end else begin
      chk(got_fault == 1'b0, "R6 no fault", 32'(got_fault), 32'd0);
      nx = (off + n > 4) ? 2 : 1;
      sp = lane_span(off, n);
      if (nx == 2) begin
        chk(xfer_n == 2, "R3 two transfers", 32'(xfer_n), 32'd2);
        chk(xa[0] == AW'(addr - off) && xs[0] == sp[3:0], "R3 first",
            {xa[0][27:0], xs[0]}, {28'(addr - off), sp[3:0]});
        chk(xa[1] == AW'(addr - off + 4) && xs[1] == sp[7:4], "R3 second",
            {xa[1][27:0], xs[1]}, {28'(addr - off + 4), sp[7:4]});
      end else begin
        chk(xfer_n == 1, "R2 one transfer", 32'(xfer_n), 32'd1);
        chk(xa[0] == AW'(addr - off) && xs[0] == sp[3:0], "R2 addr strb",
            {xa[0][27:0], xs[0]}, {28'(addr - off), sp[3:0]});
      end
      chk(done_cyc == ack_cyc + 1, "R8 done timing", 32'(done_cyc), 32'(ack_cyc + 1));
      if (wr) begin
        bit same;
        for (int i = 0; i < n; i++) shadow[addr + i] = wdata[8*i +: 8];
        same = 1'b1;
        for (int b = 0; b < MEMB; b++) if (mem[b] !== shadow[b]) same = 1'b0;
        chk(same, "R4 memory image", 32'(addr), wdata);
        chk(got == 32'd0, "R5 write result", got, 32'd0);
      end else begin
        exp_r = '0;
        for (int i = 0; i < n; i++) exp_r[8*i +: 8] = shadow[addr + i];
        chk(got == exp_r, "R5 read result", got, exp_r);
      end
    end
    @(negedge clk);
    chk(!rsp_done && req_ready, "R8 pulse and ready", {30'd0, rsp_done, req_ready}, 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R8 watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    seed_sink = $urandom(32'd4242);
    for (int b = 0; b < MEMB; b++) begin
      mem[b] = 8'($urandom);
      shadow[b] = mem[b];
    end
    rst = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(req_ready && !bus_valid && !rsp_done, "R1 reset state",
        {29'd0, req_ready, bus_valid, rsp_done}, 32'h4);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !bus_valid && !rsp_done, "R1 after release",
        {29'd0, req_ready, bus_valid, rsp_done}, 32'h4);

    // directed: every offset for word and halfword, load and store
    for (int o = 0; o < 4; o++) begin
      access(16 + o, 2, 1'b1, 32'h3355AACC + 32'(o), 0);
      access(16 + o, 2, 1'b0, 32'h0, 0);
      access(40 + o, 1, 1'b1, 32'h0000BEEF ^ 32'(o), 0);
      access(40 + o, 1, 1'b0, 32'h0, 0);
      access(60 + o, 0, 1'b1, 32'h000000A5 + 32'(o), 0);
      access(60 + o, 0, 1'b0, 32'h0, 0);
    end
    // directed: protected kinds misaligned and aligned, illegal size
    for (int k = 1; k < 4; k++) begin
      access(21, 2, 1'b0, 32'h0, k);
      access(23, 1, 1'b1, 32'h1234, k);
      access(24, 2, 1'b0, 32'h0, k);
      access(26, 1, 1'b1, 32'h5678, k);
      access(25, 0, 1'b0, 32'h0, k);
    end
    access(8, 3, 1'b0, 32'h0, 0);
    access(9, 3, 1'b1, 32'hFFFF_FFFF, 2);

    // seeded random mix
    for (int t = 0; t < 400; t++) begin
      int a, s, k;
      a = int'($urandom % 120);
      s = int'($urandom % 8);
      s = (s > 3) ? 2 : s;
      k = ($urandom % 4 == 0) ? int'($urandom % 4) : 0;
      access(a, s, 1'($urandom), $urandom, k);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule